// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This unit holds a 16-bit stack pointer and turns push and pop commands into data-memory byte accesses. The stack grows toward lower addresses, and the pointer always names the next free byte. A single-byte push writes at the pointer and then steps it down. A single-byte pop steps it up and then reads. Pushing a 16-bit return address takes two write cycles: the low byte goes to the pointer and the high byte to the byte below it. Popping a return address reads the two bytes back in the opposite order and returns the reassembled value.

Software sees the pointer as two byte-wide halves. Each half can be read at any time and loaded on its own, and a software load wins over any stack traffic in the same cycle. The data memory starts at 0x0060, after 32 register-file bytes and 64 I/O bytes. A push that would write any byte below that address is refused and reported with a fault pulse. The memory array itself is external, and its read data is expected in the same cycle as the read strobe.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the pointer reads 0x015F (the last data-memory byte), `busy` is low, and no memory access or fault is signalled.
- R2: A byte push (`cmd_op` = 1) writes `push_byte` at the current pointer in the command cycle with `lane_hi` = 0. The pointer is one lower afterwards.
- R3: A byte pop (`cmd_op` = 2) reads at pointer+1 in the command cycle, and the pointer is one higher afterwards. In the next cycle `pop_valid` is high and `pop_data` = {0x00, byte read}.
- R4: A return-address push (`cmd_op` = 3) makes two consecutive write cycles. The first writes `ret_addr[7:0]` at the pointer with `lane_hi` = 0. The second writes `ret_addr[15:8]` one address lower with `lane_hi` = 1, and `busy` is high only in that second cycle. The pointer ends two lower.
- R5: A return-address pop (`cmd_op` = 4) makes two consecutive read cycles. The first reads the high byte at pointer+1 with `lane_hi` = 1. The second reads the low byte at pointer+2 with `lane_hi` = 0. The pointer ends two higher, and in the cycle after the second read `pop_valid` is high with `pop_data` = {high, low}.
- R6: `sw_wr_hi` loads `sw_wdata` into pointer bits 15:8 and `sw_wr_lo` loads it into bits 7:0. The other half keeps its value, and the change shows on `sp_hi`/`sp_lo` in the next cycle.
- R7: In a cycle with a software load, no memory access takes place. A command presented in that cycle is dropped, and a pending second beat of a return-address operation is cancelled. The pointer takes the loaded value.
- R8: A byte push with the pointer below 0x0060, or a return-address push with the pointer below 0x0061, does not write and leaves the pointer unchanged. It raises `stk_fault` during the command cycle. Pops never fault.
- R9: A command presented while `busy` is high is ignored.
- R10: `cmd_op` values 0, 5, 6 and 7 cause no access and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R2–R5, R10) |
| push_byte | input | 8 | Data for a byte push |
| ret_addr | input | 16 | Return address for a return-address push |
| sw_wr_hi | input | 1 | Software load of pointer bits 15:8 |
| sw_wr_lo | input | 1 | Software load of pointer bits 7:0 |
| sw_wdata | input | 8 | Byte for a software load |
| sp_hi | output | 8 | Pointer bits 15:8 |
| sp_lo | output | 8 | Pointer bits 7:0 |
| busy | output | 1 | Second beat of a return-address operation in progress |
| mem_addr | output | 16 | Data-memory byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the strobe cycle |
| lane_hi | output | 1 | Access carries the high byte of a return address |
| pop_valid | output | 1 | Popped value is available |
| pop_data | output | 16 | Popped value |
| stk_fault | output | 1 | Push refused for crossing the data-memory base |

## Verification
Two situations are hard to reach from the ports. The first is a software load landing exactly in the second beat of a return-address push, which leaves a half-written frame and a pointer assembled from one stepped half and one loaded half. The bench times that load to the cycle in which `busy` is high and checks that only the first beat reached memory. The second is the base-address fault, which needs the pointer at 0x0060 and 0x0061. The bench gets there by loading both halves directly rather than by pushing some 250 bytes, and it then tries both push widths at each value.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;

  // command codes
  localparam logic [2:0] OP_PUSH_B  = 3'd1;
  localparam logic [2:0] OP_POP_B   = 3'd2;
  localparam logic [2:0] OP_PUSH_RA = 3'd3;
  localparam logic [2:0] OP_POP_RA  = 3'd4;

  typedef enum logic [1:0] {STEP_HOLD, STEP_DEC, STEP_INC} step_e;
  typedef enum logic [1:0] {BEAT_IDLE, BEAT_PUSH_HI, BEAT_POP_LO} beat_e;

  // pointer after one byte step
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p, input step_e s);
    case (s)
      STEP_DEC: return p - 1'b1;
      STEP_INC: return p + 1'b1;
      default:  return p;
    endcase
  endfunction

  // pops pre-increment: the byte above the pointer is read
  function automatic logic [PTR_W-1:0] pop_addr(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  // true when nbytes written downward from p all stay at or above base
  function automatic logic push_fits(input logic [PTR_W-1:0] p,
                                     input logic [PTR_W-1:0] nbytes,
                                     input logic [PTR_W-1:0] base);
    return (p >= base) && ((p - base) >= (nbytes - 1'b1));
  endfunction
endpackage

// File: rtl/stkptr_guard.sv
module stkptr_guard
  import stkptr_pkg::*;
#(
  parameter logic [PTR_W-1:0] SRAM_BASE = 16'h0060
) (
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [PTR_W-1:0] ptr,
  output logic             push_blocked
);
  logic fits_byte, fits_ret;

  assign fits_byte = push_fits(ptr, 16'd1, SRAM_BASE);
  assign fits_ret  = push_fits(ptr, 16'd2, SRAM_BASE);

  always_comb begin
    push_blocked = 1'b0;
    if (cmd_valid) begin
      if (cmd_op == OP_PUSH_B)  push_blocked = !fits_byte;
      if (cmd_op == OP_PUSH_RA) push_blocked = !fits_ret;
    end
  end
endmodule

// File: rtl/stkptr_reg.sv
module stkptr_reg
  import stkptr_pkg::*;
#(
  parameter logic [PTR_W-1:0] RESET_VAL = 16'h015F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_hi,
  input  logic              sw_wr_lo,
  input  logic [BYTE_W-1:0] sw_wdata,
  input  step_e             step,
  output logic [PTR_W-1:0]  ptr
);
  localparam int HALVES = PTR_W / BYTE_W;

  logic [HALVES-1:0] wr_half;
  logic [PTR_W-1:0]  stepped;

  assign wr_half = {sw_wr_hi, sw_wr_lo};
  assign stepped = step_ptr(ptr, step);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [BYTE_W-1:0] half_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          half_q <= RESET_VAL[h*BYTE_W +: BYTE_W];
      else if (wr_half[h]) half_q <= sw_wdata;
      else                 half_q <= stepped[h*BYTE_W +: BYTE_W];
    end
    assign ptr[h*BYTE_W +: BYTE_W] = half_q;
  end
endmodule

// File: rtl/stkptr_seq.sv
module stkptr_seq
  import stkptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] push_byte,
  input  logic [PTR_W-1:0]  ret_addr,
  input  logic              sw_any,
  input  logic              push_blocked,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output step_e             step,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              lane_hi,
  output logic              busy,
  output logic              stk_fault,
  output logic              pop_valid,
  output logic [PTR_W-1:0]  pop_data
);
  beat_e             beat_q, beat_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              take;       // command accepted this cycle
  logic              fin_byte;   // last read of a byte pop
  logic              fin_ret;    // last read of a return-address pop

  assign busy = (beat_q != BEAT_IDLE);
  assign take = cmd_valid && !busy && !sw_any;

  always_comb begin
    beat_d    = BEAT_IDLE;
    hold_d    = hold_q;
    step      = STEP_HOLD;
    mem_addr  = ptr;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    lane_hi   = 1'b0;
    stk_fault = 1'b0;
    fin_byte  = 1'b0;
    fin_ret   = 1'b0;
    if (!sw_any) begin
      case (beat_q)
        BEAT_IDLE: if (take) begin
          case (cmd_op)
            OP_PUSH_B: begin
              if (push_blocked) stk_fault = 1'b1;
              else begin
                mem_we    = 1'b1;
                mem_wdata = push_byte;
                step      = STEP_DEC;
              end
            end
            OP_POP_B: begin
              mem_re   = 1'b1;
              mem_addr = pop_addr(ptr);
              step     = STEP_INC;
              fin_byte = 1'b1;
            end
            OP_PUSH_RA: begin
              if (push_blocked) stk_fault = 1'b1;
              else begin
                mem_we    = 1'b1;
                mem_wdata = ret_addr[BYTE_W-1:0];
                step      = STEP_DEC;
                hold_d    = ret_addr[PTR_W-1:BYTE_W];
                beat_d    = BEAT_PUSH_HI;
              end
            end
            OP_POP_RA: begin
              mem_re   = 1'b1;
              mem_addr = pop_addr(ptr);
              lane_hi  = 1'b1;
              step     = STEP_INC;
              hold_d   = mem_rdata;
              beat_d   = BEAT_POP_LO;
            end
            default: ;
          endcase
        end
        BEAT_PUSH_HI: begin
          mem_we    = 1'b1;
          mem_wdata = hold_q;
          lane_hi   = 1'b1;
          step      = STEP_DEC;
        end
        BEAT_POP_LO: begin
          mem_re   = 1'b1;
          mem_addr = pop_addr(ptr);
          step     = STEP_INC;
          fin_ret  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q    <= BEAT_IDLE;
      hold_q    <= '0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      beat_q    <= beat_d;
      hold_q    <= hold_d;
      pop_valid <= fin_byte | fin_ret;
      if (fin_ret)       pop_data <= {hold_q, mem_rdata};
      else if (fin_byte) pop_data <= {{(PTR_W-BYTE_W){1'b0}}, mem_rdata};
    end
  end
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter logic [PTR_W-1:0] SRAM_BASE = 16'h0060,
  parameter logic [PTR_W-1:0] SRAM_LAST = 16'h015F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] push_byte,
  input  logic [PTR_W-1:0]  ret_addr,
  input  logic              sw_wr_hi,
  input  logic              sw_wr_lo,
  input  logic [BYTE_W-1:0] sw_wdata,
  output logic [BYTE_W-1:0] sp_hi,
  output logic [BYTE_W-1:0] sp_lo,
  output logic              busy,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              lane_hi,
  output logic              pop_valid,
  output logic [PTR_W-1:0]  pop_data,
  output logic              stk_fault
);
  logic [PTR_W-1:0] ptr;
  logic             sw_any;
  logic             push_blocked;
  step_e            step;

  assign sw_any = sw_wr_hi | sw_wr_lo;
  assign sp_hi  = ptr[PTR_W-1:BYTE_W];
  assign sp_lo  = ptr[BYTE_W-1:0];

  stkptr_guard #(.SRAM_BASE(SRAM_BASE)) u_guard (
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .ptr         (ptr),
    .push_blocked(push_blocked)
  );

  stkptr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .push_byte   (push_byte),
    .ret_addr    (ret_addr),
    .sw_any      (sw_any),
    .push_blocked(push_blocked),
    .ptr         (ptr),
    .mem_rdata   (mem_rdata),
    .step        (step),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_wdata   (mem_wdata),
    .lane_hi     (lane_hi),
    .busy        (busy),
    .stk_fault   (stk_fault),
    .pop_valid   (pop_valid),
    .pop_data    (pop_data)
  );

  stkptr_reg #(.RESET_VAL(SRAM_LAST)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_wr_hi(sw_wr_hi),
    .sw_wr_lo(sw_wr_lo),
    .sw_wdata(sw_wdata),
    .step    (step),
    .ptr     (ptr)
  );
endmodule

// File: rtl/stkptr_sva.sv
module stkptr_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sp_hi,
  input logic [7:0]  sp_lo,
  input logic        busy,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        mem_re,
  input logic        lane_hi,
  input logic        pop_valid,
  input logic        stk_fault,
  input logic        sw_wr_hi,
  input logic        sw_wr_lo
);
  logic [15:0] sp;
  assign sp = {sp_hi, sp_lo};

  p_wr_at_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp);
  p_wr_steps_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 16'd1);
  p_rd_above_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr == sp + 16'd1);
  p_rd_steps_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == $past(sp) + 16'd1);
  p_busy_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  p_pop_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> $past(mem_re));
  p_sw_blocks_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_hi || sw_wr_lo) |-> !mem_we && !mem_re);
  p_fault_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stk_fault |-> !mem_we && !mem_re);
  p_fault_keeps_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stk_fault |=> $stable(sp));
  p_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re) && !(lane_hi && !(mem_we || mem_re)));
endmodule

bind stkptr_unit stkptr_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .sp_hi    (sp_hi),
  .sp_lo    (sp_lo),
  .busy     (busy),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .lane_hi  (lane_hi),
  .pop_valid(pop_valid),
  .stk_fault(stk_fault),
  .sw_wr_hi (sw_wr_hi),
  .sw_wr_lo (sw_wr_lo)
);

// File: tb/tb_stkptr_unit.sv
module tb_stkptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  push_byte = '0;
  logic [15:0] ret_addr = '0;
  logic        sw_wr_hi = 1'b0, sw_wr_lo = 1'b0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  sp_hi, sp_lo, mem_wdata, mem_rdata;
  logic        busy, mem_we, mem_re, lane_hi, pop_valid, stk_fault;
  logic [15:0] mem_addr, pop_data;

  always #2.5 clk = ~clk;

  stkptr_unit dut (.*);

  // memory model
  logic [7:0] mem [0:511];
  assign mem_rdata = mem[mem_addr[8:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;

  // scoreboard
  typedef struct packed {logic we; logic lane; logic [15:0] addr; logic [7:0] data;} acc_t;
  acc_t        exp_q[$];
  logic [15:0] pop_q[$];
  logic [7:0]  sh [0:511];
  logic [15:0] sp_m;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  acc_t        mon_e;
  logic [15:0] mon_p;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: sample shortly before each rising edge
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n) begin
      if (mem_we || mem_re) begin
        if (exp_q.size() == 0)
          chk("unexpected access R7 R9 R10", {mem_we, mem_re, mem_addr}, 32'h0);
        else begin
          mon_e = exp_q.pop_front();
          chk("access kind R2 R3 R4 R5", {mem_we, lane_hi, mem_addr}, {mon_e.we, mon_e.lane, mon_e.addr});
          if (mon_e.we) chk("write data R2 R4", mem_wdata, mon_e.data);
        end
      end
      if (pop_valid) begin
        if (pop_q.size() == 0) chk("unexpected pop R3 R5", pop_data, 32'hFFFF_FFFF);
        else begin
          mon_p = pop_q.pop_front();
          chk("pop data R3 R5", pop_data, mon_p);
        end
      end
    end
  end

  // driver: queue expected accesses, then apply one command
  task automatic run_cmd(input logic [2:0] op, input logic [7:0] b, input logic [15:0] ra);
    logic f, two;
    logic [15:0] a1, a2;
    f = 0; two = 0;
    a1 = sp_m + 16'd1; a2 = sp_m + 16'd2;
    case (op)
      3'd1: if (sp_m < 16'h0060) f = 1;
            else begin
              exp_q.push_back('{1'b1, 1'b0, sp_m, b});
              sh[sp_m[8:0]] = b; sp_m = sp_m - 16'd1;
            end
      3'd2: begin
              exp_q.push_back('{1'b0, 1'b0, a1, 8'h00});
              pop_q.push_back({8'h00, sh[a1[8:0]]}); sp_m = a1;
            end
      3'd3: if (sp_m < 16'h0061) f = 1;
            else begin
              two = 1;
              exp_q.push_back('{1'b1, 1'b0, sp_m, ra[7:0]});
              sh[sp_m[8:0]] = ra[7:0];
              sp_m = sp_m - 16'd1;
              exp_q.push_back('{1'b1, 1'b1, sp_m, ra[15:8]});
              sh[sp_m[8:0]] = ra[15:8];
              sp_m = sp_m - 16'd1;
            end
      3'd4: begin
              two = 1;
              exp_q.push_back('{1'b0, 1'b1, a1, 8'h00});
              exp_q.push_back('{1'b0, 1'b0, a2, 8'h00});
              pop_q.push_back({sh[a1[8:0]], sh[a2[8:0]]}); sp_m = a2;
            end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; push_byte = b; ret_addr = ra;
    #1.5 chk("R8 fault flag", stk_fault, f);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    if (two) begin
      chk("R4 R5 busy in second beat", busy, 1'b1);
      @(negedge clk);
    end
    chk("pointer after command R2 R3 R4 R5 R8 R10", {sp_hi, sp_lo}, sp_m);
  endtask

  initial begin
    #(5 * 100000);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    sp_m = 16'h015F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1.5;
    // R1 reset state
    chk("R1 reset pointer", {sp_hi, sp_lo}, 16'h015F);
    chk("R1 reset idle", {busy, mem_we, mem_re, stk_fault, pop_valid}, 5'b0);

    // R2 byte pushes, R3 byte pop
    run_cmd(3'd1, 8'hA1, 16'h0);
    run_cmd(3'd1, 8'hB2, 16'h0);
    run_cmd(3'd1, 8'hC3, 16'h0);
    run_cmd(3'd2, 8'h00, 16'h0);
    // R4 / R5 return addresses, nested
    run_cmd(3'd3, 8'h00, 16'h1234);
    run_cmd(3'd3, 8'h00, 16'hBEEF);
    run_cmd(3'd4, 8'h00, 16'h0);
    run_cmd(3'd4, 8'h00, 16'h0);
    run_cmd(3'd2, 8'h00, 16'h0);
    run_cmd(3'd2, 8'h00, 16'h0);
    chk("R3 R5 pointer back at top", {sp_hi, sp_lo}, 16'h015F);

    // R10 unused codes
    for (int k = 5; k < 8; k++) run_cmd(3'(k), 8'h77, 16'h7777);
    run_cmd(3'd0, 8'h77, 16'h7777);

    // R6 separate halves
    @(negedge clk); sw_wr_lo = 1; sw_wdata = 8'h61;
    @(negedge clk); sw_wr_lo = 0;
    chk("R6 low half load", {sp_hi, sp_lo}, 16'h0161);
    @(negedge clk); sw_wr_hi = 1; sw_wdata = 8'h00;
    @(negedge clk); sw_wr_hi = 0;
    chk("R6 high half load", {sp_hi, sp_lo}, 16'h0061);
    sp_m = 16'h0061;

    // R8 base boundary
    run_cmd(3'd3, 8'h00, 16'h4D3C);   // fits exactly: 0x61, 0x60
    run_cmd(3'd1, 8'h11, 16'h0);      // pointer 0x5F: fault
    run_cmd(3'd3, 8'h00, 16'h2222);   // fault
    run_cmd(3'd2, 8'h00, 16'h0);      // pops never fault, reads 0x60
    run_cmd(3'd3, 8'h00, 16'h3333);   // pointer 0x60: fault
    run_cmd(3'd1, 8'h5E, 16'h0);      // pointer 0x60: byte fits
    run_cmd(3'd1, 8'h5F, 16'h0);      // pointer 0x5F: fault

    // R7 software load wins over a command in the same cycle
    @(negedge clk); sw_wr_hi = 1; sw_wdata = 8'h01;
    @(negedge clk); sw_wr_hi = 0;
    sp_m = 16'h015F;
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd1; push_byte = 8'h99; sw_wr_lo = 1; sw_wdata = 8'h40;
    #1.5 chk("R7 no access with load", {mem_we, mem_re}, 2'b00);
    @(negedge clk); cmd_valid = 0; sw_wr_lo = 0;
    sp_m = 16'h0140;
    chk("R7 pointer takes load", {sp_hi, sp_lo}, sp_m);

    // R7 load in the second beat cancels it
    exp_q.push_back('{1'b1, 1'b0, sp_m, 8'h5A});
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd3; ret_addr = 16'hA55A;
    @(negedge clk); cmd_valid = 0; sw_wr_hi = 1; sw_wdata = 8'h00;
    #1.5 chk("R7 second beat cancelled", {mem_we, busy}, 2'b01);
    @(negedge clk); sw_wr_hi = 0;
    sp_m = 16'h003F;
    chk("R7 pointer after cancel", {sp_hi, sp_lo}, sp_m);
    chk("R7 busy cleared", busy, 1'b0);

    // R9 command during busy ignored
    @(negedge clk); sw_wr_hi = 1; sw_wdata = 8'h01;
    @(negedge clk); sw_wr_hi = 0; sw_wr_lo = 1; sw_wdata = 8'h20;
    @(negedge clk); sw_wr_lo = 0;
    sp_m = 16'h0120;
    exp_q.push_back('{1'b1, 1'b0, 16'h0120, 8'hCD});
    exp_q.push_back('{1'b1, 1'b1, 16'h011F, 8'hAB});
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd3; ret_addr = 16'hABCD;
    @(negedge clk); cmd_op = 3'd1; push_byte = 8'hEE;   // held while busy
    @(negedge clk); cmd_valid = 0; cmd_op = 0;
    sp_m = 16'h011E;
    chk("R9 command in busy ignored", {sp_hi, sp_lo}, sp_m);

    repeat (3) @(negedge clk);
    chk("scoreboard drained R2 R3 R4 R5", exp_q.size() + pop_q.size(), 0);
    finish_run();
  end
endmodule